// File: doc/BRIEF.md
# DMA Channel Enable and Suspend Control

This block holds the control state of a single DMA channel and decides, cycle by cycle, whether that channel may run. A channel runs only while two enables are both set: a master enable in the control byte and a separate channel enable. A non-maskable interrupt pulse forces the master enable off, which suspends the channel so the processor can use the bus. Software may then turn the master enable on again, but only by reading the control byte while the bit is clear and then writing a 1 to it. The channel then carries on with its destination address and any request it still holds.

The block also holds the destination address register. On each completed transfer, the control bits decide whether this register holds, steps up or steps down by a fixed unit. A transfer-done strobe stands in for the arbiter, the counters and the data path, which are outside this block. A request latch watches one of eight activation lines, chosen by a select field, and raises the transfer request while the channel runs. Entering standby clears the control byte and drops any held request.

Top module: `dma_chan_ctl`

## Requirements
- R1: `chan_active` is 1 exactly when the master enable (control byte bit 7) and the channel enable (register 1, bit 0) are both 1.
- R2: An `nmi` pulse clears the master enable at the next clock edge. This holds even when the same cycle writes a 1 to bit 7. The other bits of such a write are still stored.
- R3: A write to register 0 sets the master enable only if bit 7 of the write is 1 and the arming flag is set. A read of register 0 (`bus_rd`, `bus_addr`=0) while the master enable is 0 sets the arming flag. A write of 1 without arming leaves the master enable at 0.
- R4: Every bus write clears the arming flag, whatever its address or data. `nmi` and `standby` also clear it. A write to register 0 with bit 7 at 0 clears the master enable. When read and write come in the same cycle, the write decides.
- R5: After reset, register 0 reads 0, the channel enable is 0, the destination address is 0 and no request is held. While `standby` is high, each clock clears register 0 and the held request. The channel enable and the destination address are kept.
- R6: Control byte layout: bit 6 is a spare bit that can be written and read. Bit 5 is the step direction (1 means decrement). Bit 4 is the step enable. Bit 3 is the block-side select, which is stored and read back. Bits 2:0 are the activation source select.
- R7: A `xfer_done` pulse while the channel is active changes the destination address. It holds if the step enable is 0. Otherwise it adds STEP (direction 0) or subtracts STEP (direction 1), modulo 2^DATA_W. A bus write to register 2 in the same cycle wins over the step.
- R8: While the channel is inactive, `xfer_done` is ignored: the destination address and the held request keep their values. After re-enabling, both are seen unchanged.
- R9: A high level on `act_src[sel]` sets the held request, where sel is control bits 2:0. `xfer_done` while active clears it, and a new set in the same cycle wins. `xfer_req` equals the held request ANDed with `chan_active`.
- R10: `bus_rdata` follows `bus_addr` combinationally, whether or not `bus_rd` is asserted. Address 0 gives the control byte, zero-extended. Address 1 gives the channel enable in bit 0. Address 2 gives the destination address. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby level; clears control byte and held request |
| nmi | input | 1 | Non-maskable interrupt pulse; suspends the channel |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| act_src | input | 8 | Activation request lines, one per source |
| xfer_done | input | 1 | One transfer completed |
| chan_active | output | 1 | Channel enabled to run |
| xfer_req | output | 1 | Held request presented while active |
| dest_addr | output | DATA_W | Destination address register |

## Verification
The bench builds the block with a 12-bit data and address width and a step of 4. With this narrow width, decrementing from 0 wraps to 0xFFC, so wrap-around in both directions comes up within a few transfers. The larger step makes an off-by-one or a step taken twice show up at once. The random stimulus mixes arming reads, stray writes, NMI and standby with enables changing underneath. This covers arming races, suspended transfers and resumption.

// File: rtl/dma_chan_ctl_pkg.sv
// Package: register indices and control byte layout shared by the channel
// control block, its submodules and its checker.
package dma_chan_ctl_pkg;

    localparam int SEL_W = 3;
    localparam int NSRC  = 1 << SEL_W;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_CEN  = 2'd1;
    localparam logic [1:0] REG_DEST = 2'd2;

    // Control byte, MSB first: master enable at bit 7, select at bits 2:0.
    typedef struct packed {
        logic             run_en;
        logic             spare;
        logic             step_dn;
        logic             step_en;
        logic             blk_side;
        logic [SEL_W-1:0] src_sel;
    } ctl_byte_t;

endpackage

// File: rtl/dma_chan_ctl_regs.sv
// Control byte, arming flag and channel enable.
// Assumes one bus operation per cycle; a write outranks a read.
// The master enable is set only after an arming read; nmi clears it and
// wins over a write; standby clears the whole control byte.
module dma_chan_ctl_regs
    import dma_chan_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       nmi,
    input  logic       rd,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wbyte,
    output ctl_byte_t  ctl_q,
    output logic       cen_q,
    output logic       arm_q
);

    logic ctl_wr;
    logic ctl_rd;

    always_comb begin
        // Decode accesses to the control byte.
        ctl_wr = wr && (addr == REG_CTL);
        ctl_rd = rd && !wr && (addr == REG_CTL);
    end

    // Channel enable: reset only, untouched by standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q <= 1'b0;
        end else if (wr && (addr == REG_CEN)) begin
            cen_q <= wbyte[0];
        end
    end

    // Control byte and arming flag with nmi and standby overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            arm_q <= 1'b0;
        end else if (standby) begin
            ctl_q <= '0;
            arm_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q.spare    <= wbyte[6];
                ctl_q.step_dn  <= wbyte[5];
                ctl_q.step_en  <= wbyte[4];
                ctl_q.blk_side <= wbyte[3];
                ctl_q.src_sel  <= wbyte[SEL_W-1:0];
            end
            if (nmi) begin
                ctl_q.run_en <= 1'b0;
            end else if (ctl_wr) begin
                ctl_q.run_en <= wbyte[7] & (ctl_q.run_en | arm_q);
            end
            if (nmi || wr) begin
                arm_q <= 1'b0;
            end else if (ctl_rd) begin
                arm_q <= ~ctl_q.run_en;
            end
        end
    end

endmodule

// File: rtl/dma_chan_dest_step.sv
// Destination address register.
// A load has priority over a step; a step moves by STEP up or down,
// wrapping modulo 2^WIDTH. Assumes advance is already gated by activity.
module dma_chan_dest_step #(
    parameter int WIDTH = 32,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             advance,
    input  logic             down,
    output logic [WIDTH-1:0] addr_q
);

    localparam logic [WIDTH-1:0] STEP_V = WIDTH'(STEP);

    logic [WIDTH-1:0] stepped;

    always_comb begin
        // Next address for one step in the selected direction.
        stepped = down ? (addr_q - STEP_V) : (addr_q + STEP_V);
    end

    // Hold, load or step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (advance) begin
            addr_q <= stepped;
        end
    end

endmodule

// File: rtl/dma_chan_req_latch.sv
// Held transfer request. Picks one activation line by the select field;
// a new request wins over a same-cycle serve; standby drops the request.
// Assumes serve is already gated by channel activity, so a suspended
// channel keeps its request.
module dma_chan_req_latch
    import dma_chan_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [NSRC-1:0]  act_src,
    input  logic [SEL_W-1:0] sel,
    input  logic             serve,
    output logic             pend_q
);

    logic [NSRC-1:0] hit_vec;
    logic            hit;

    // One match term per activation source.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit_vec[g] = act_src[g] && (sel == SEL_W'(g));
    end

    always_comb begin
        // Any selected line raised.
        hit = |hit_vec;
    end

    // Set, serve or hold the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (standby) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (serve) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_ctl.sv
// Single DMA channel control: register port, enable gating, NMI suspend,
// destination stepping and request holding. Assumes DATA_W >= 8, a
// synchronous active-low reset and single-cycle bus strobes.
module dma_chan_ctl
    import dma_chan_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              nmi,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   act_src,
    input  logic              xfer_done,
    output logic              chan_active,
    output logic              xfer_req,
    output logic [DATA_W-1:0] dest_addr
);

    ctl_byte_t ctl_q;
    logic      cen_q;
    logic      arm_q;
    logic      pend_q;
    logic      dest_load;
    logic      serve;
    logic      advance;

    dma_chan_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .nmi     (nmi),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wbyte   (bus_wdata[7:0]),
        .ctl_q   (ctl_q),
        .cen_q   (cen_q),
        .arm_q   (arm_q)
    );

    always_comb begin
        // Channel gating and the per-transfer strobes derived from it.
        chan_active = ctl_q.run_en & cen_q;
        dest_load   = bus_wr && (bus_addr == REG_DEST);
        serve       = xfer_done && chan_active;
        advance     = serve && ctl_q.step_en;
    end

    dma_chan_dest_step #(
        .WIDTH (DATA_W),
        .STEP  (STEP)
    ) u_dest (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dest_load),
        .load_val (bus_wdata),
        .advance  (advance),
        .down     (ctl_q.step_dn),
        .addr_q   (dest_addr)
    );

    dma_chan_req_latch u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .act_src (act_src),
        .sel     (ctl_q.src_sel),
        .serve   (serve),
        .pend_q  (pend_q)
    );

    always_comb begin
        // Request output is masked while suspended.
        xfer_req = pend_q & chan_active;
    end

    always_comb begin
        // Register read multiplexer.
        bus_rdata = '0;
        case (bus_addr)
            REG_CTL:  bus_rdata = DATA_W'(ctl_q);
            REG_CEN:  bus_rdata = DATA_W'(cen_q);
            REG_DEST: bus_rdata = dest_addr;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_ctl_chk.sv
// Checker for dma_chan_ctl: temporal properties on ports and on state
// held in separate submodules. Attached by the bind at the end of file.
module dma_chan_ctl_chk #(
    parameter int DATA_W = 32,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              nmi,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic              xfer_done,
    input  logic              chan_active,
    input  logic              xfer_req,
    input  logic [DATA_W-1:0] dest_addr,
    input  logic [7:0]        ctl_byte,
    input  logic              arm
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    p_inactive_without_master_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_byte[7] |-> !chan_active);

    p_nmi_clears_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !ctl_byte[7]);

    p_set_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_byte[7]) |-> $past(arm));

    p_write_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !arm);

    p_standby_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctl_byte == 8'h00) && !xfer_req);

    p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && xfer_done && ctl_byte[4] && !ctl_byte[5]
         && !(bus_wr && bus_addr == 2'd2))
        |=> dest_addr == $past(dest_addr) + STEP_V);

    p_frozen_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_active && !(bus_wr && bus_addr == 2'd2)) |=> $stable(dest_addr));

    p_req_only_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> chan_active);

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(
    .DATA_W (DATA_W),
    .STEP   (STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .nmi         (nmi),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .xfer_done   (xfer_done),
    .chan_active (chan_active),
    .xfer_req    (xfer_req),
    .dest_addr   (dest_addr),
    .ctl_byte    (ctl_q),
    .arm         (arm_q)
);

// File: tb/dma_chan_ctl_tb_top.sv
// Bench for dma_chan_ctl: directed corner cases, then seeded random
// vectors, all compared against a reference model kept in bench tasks.
module dma_chan_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int STEP       = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          standby, nmi, bus_rd, bus_wr, xfer_done;
    logic [1:0]    bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, dest_addr;
    logic [7:0]    act_src;
    logic          chan_active, xfer_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 1'b0;

    // Reference state
    logic [7:0]    m_ctl;
    logic          m_cen, m_arm, m_pend;
    logic [DW-1:0] m_dest;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctl #(.DATA_W(DW), .STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby), .nmi(nmi),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_src(act_src),
        .xfer_done(xfer_done), .chan_active(chan_active),
        .xfer_req(xfer_req), .dest_addr(dest_addr)
    );

    function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return DW'(m_ctl);
            2'd1:    return DW'(m_cen);
            2'd2:    return m_dest;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Compare every register and output; called in the low clock phase.
    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            chk({tag, "/R10 read"}, bus_rdata, exp_read(2'(a)));
        end
        chk({tag, "/R1 active"}, DW'(chan_active), DW'(m_ctl[7] & m_cen));
        chk({tag, "/R9 req"}, DW'(xfer_req), DW'(m_pend & m_ctl[7] & m_cen));
        chk({tag, "/R7 dest"}, dest_addr, m_dest);
    endtask

    // One clock of stimulus; the model advances by the requirement rules.
    task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                       input logic [DW-1:0] wd, input logic nm, input logic sb,
                       input logic [7:0] src, input logic dn);
        logic act;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        nmi = nm; standby = sb; act_src = src; xfer_done = dn;
        act = m_ctl[7] & m_cen;
        if (wr && a == 2'd2)
            m_dest = wd;
        else if (dn && act && m_ctl[4])
            m_dest = m_ctl[5] ? m_dest - DW'(STEP) : m_dest + DW'(STEP);
        if (sb) m_pend = 1'b0;
        else if (src[m_ctl[2:0]]) m_pend = 1'b1;
        else if (dn && act) m_pend = 1'b0;
        if (wr && a == 2'd1) m_cen = wd[0];
        if (sb) begin
            m_ctl = 8'h00; m_arm = 1'b0;
        end else begin
            logic new_me;
            new_me = m_ctl[7];
            if (nm) new_me = 1'b0;
            else if (wr && a == 2'd0) new_me = wd[7] & (m_ctl[7] | m_arm);
            if (nm || wr) m_arm = 1'b0;
            else if (rd && a == 2'd0) m_arm = ~m_ctl[7];
            if (wr && a == 2'd0) m_ctl[6:0] = wd[6:0];
            m_ctl[7] = new_me;
        end
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; nmi = 0; standby = 0; act_src = 0; xfer_done = 0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
        cyc(0, 1, a, d, 0, 0, 8'h00, 0);
    endtask

    task automatic rd_reg(input logic [1:0] a);
        cyc(1, 0, a, '0, 0, 0, 8'h00, 0);
    endtask

    task automatic done_pulse();
        cyc(0, 0, 2'd3, '0, 0, 0, 8'h00, 1);
    endtask

    task automatic finish_run();
        if (!done_f) begin
            done_f = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 0; standby = 0; nmi = 0; bus_rd = 0; bus_wr = 0;
        bus_addr = 0; bus_wdata = 0; act_src = 0; xfer_done = 0;
        m_ctl = 0; m_cen = 0; m_arm = 0; m_pend = 0; m_dest = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R5 reset");

        // R3: write 1 without arming read must not set master enable
        wr_reg(2'd0, 12'h080);
        check_all("R3 unarmed");
        chk("R3 unarmed bit7", DW'(dut_i.chan_active), 0);
        // R3: arming read then write 1
        rd_reg(2'd0);
        wr_reg(2'd0, 12'h090);
        wr_reg(2'd1, 12'h001);
        check_all("R3 armed set, R1 active");
        chk("R1 active", DW'(chan_active), 1);

        // R7: increment, decrement with wrap, hold
        wr_reg(2'd2, 12'h000);
        done_pulse();
        check_all("R7 inc");
        rd_reg(2'd0); wr_reg(2'd0, 12'h0B0);      // dir down, step on, keep master
        done_pulse(); done_pulse(); done_pulse();
        check_all("R7 dec wrap");
        chk("R7 wrap value", dest_addr, 12'hFF8);
        wr_reg(2'd0, 12'h080);                    // step off
        done_pulse();
        check_all("R7 hold");
        // R7: bus write beats step in same cycle
        wr_reg(2'd0, 12'h090);
        cyc(0, 1, 2'd2, 12'h123, 0, 0, 8'h00, 1);
        check_all("R7 load priority");

        // R8/R9: request held across NMI suspend and resumed
        wr_reg(2'd0, 12'h095);                    // select source 5
        cyc(0, 0, 2'd3, '0, 0, 0, 8'h20, 0);
        check_all("R9 set");
        cyc(0, 0, 2'd3, '0, 1, 0, 8'h00, 0);      // NMI
        check_all("R2 nmi");
        done_pulse(); done_pulse();
        check_all("R8 frozen");
        chk("R8 dest frozen", dest_addr, 12'h123);
        rd_reg(2'd0); wr_reg(2'd0, 12'h095);
        check_all("R8 resumed");
        chk("R9 req resumed", DW'(xfer_req), 1);
        done_pulse();
        check_all("R9 served");

        // R4: intervening write to another register disarms
        wr_reg(2'd0, 12'h015);
        rd_reg(2'd0);
        wr_reg(2'd1, 12'h001);
        wr_reg(2'd0, 12'h095);
        check_all("R4 disarmed");
        chk("R4 master stays 0", DW'(chan_active), 0);
        // R2: NMI beats armed write of 1; low bits still stored, R6 spare
        rd_reg(2'd0);
        cyc(0, 1, 2'd0, 12'h0C2, 1, 0, 8'h00, 0);
        check_all("R2 nmi wins, R6 spare");
        bus_addr = 2'd0; #1;
        chk("R6 spare readback", bus_rdata, 12'h042);

        // R5: standby clears control and request, keeps enable and dest
        rd_reg(2'd0); wr_reg(2'd0, 12'h0D5);
        cyc(0, 0, 2'd3, '0, 0, 0, 8'h20, 0);
        cyc(0, 0, 2'd3, '0, 0, 1, 8'h00, 0);
        check_all("R5 standby");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic rd, wr, nm, sb, dn;
            logic [1:0] a;
            logic [DW-1:0] wd;
            r  = $urandom_range(0, 99);
            rd = (r < 30);
            wr = (r >= 25 && r < 60);
            a  = (r < 45) ? 2'd0 : 2'($urandom_range(0, 3));
            wd = DW'($urandom());
            if ($urandom_range(0, 2) == 0) wd[7] = 1'b1;
            if (a == 2'd1 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
            nm = ($urandom_range(0, 39) == 0);
            sb = ($urandom_range(0, 149) == 0);
            dn = ($urandom_range(0, 2) == 0);
            cyc(rd, wr, a, wd, nm, sb, 8'($urandom()) & 8'($urandom()), dn);
            check_all("random");
        end
        finish_run();
    end

endmodule